// File: doc/BRIEF.md
# Latched 64-bit Free-Running Counter

This block keeps a 64-bit up-counter that advances by one on every clock cycle in which its tick-enable input is high. Software never reads the live count. It asks the block to capture the count into a 64-bit snapshot and then reads that snapshot as two 32-bit words, the low word first and then the high word. Both words always come from the same capture, so a carry between the halves can never tear a read.

Control goes through one register. Clearing the counter and capturing a snapshot are each started by writing a 1 to a command bit. That bit then reads back as 1 while the hardware works and falls to 0 when the action is complete, so software polls it. Each action completes a fixed two cycles after the write, which stands in for the synchronisation delay of a slower counter domain. A sync bit, pulsed high and then low by software, freezes the count while it is set. This allows the counter to be aligned with another counter.

The register port is a plain write strobe with address and data and a combinational read path. The clock source and any clock-domain synchroniser sit outside the block.

Top module: `latched_counter64`

## Requirements
- R1: After a synchronous active-low reset, the counter, the snapshot, both command bits and the sync bit are all zero, and every register reads 0.
- R2: A write to offset 0x0 with bit 0 set starts a clear. Bit 0 of offset 0x0 reads 1 during the two cycles after the write edge. At the second clock edge after the write edge, the counter becomes zero and bit 0 returns to 0.
- R3: A write to offset 0x0 with bit 1 set starts a capture. Bit 1 of offset 0x0 reads 1 during the two cycles after the write edge. At the second clock edge after the write edge, the snapshot takes the counter value held just before that edge and bit 1 returns to 0.
- R4: Reading offset 0x4 returns snapshot bits 31:0 and reading offset 0x8 returns snapshot bits 63:32. Offset 0x0 returns the clear-busy bit in bit 0, the capture-busy bit in bit 1 and the sync bit in bit 4. All other control bits, and offset 0xC, read 0.
- R5: The counter increases by exactly one at each clock edge where the tick input is high, sync is clear and no clear completes. Otherwise it keeps its value. Counting is modulo 2^64.
- R6: Every write to offset 0x0 loads bit 4 of the data into the sync bit. While the sync bit is 1, ticks do not advance the counter. Counting resumes once a write returns the bit to 0.
- R7: The snapshot words change only when a capture completes. Counting, clears and sync changes leave them untouched.
- R8: A command bit written as 1 while that same command is already busy is ignored: its busy bit still falls at the second edge after the first write, and no second action follows.
- R9: When bits 0 and 1 are written together, the capture takes the count from before the clear, and the counter is zero afterwards.
- R10: Writes to offsets 0x4, 0x8 and 0xC change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count enable; the counter advances on each edge where it is high |
| reg_wr | input | 1 | Register write strobe, sampled on the rising edge |
| reg_addr | input | 4 | Byte offset of the register accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |

## Verification
Different results fall due at different times after a stimulus. A command write shows its busy bit in the cycle right after the write edge. Its effect (the zeroed count or the new snapshot) and the falling busy bit both land at the second edge after the write. A tick or a sync change affects the count at the very next edge. The reference model in the bench advances once per rising edge with the same pre-edge inputs and pending-action counters. Between edges, the bench reads every register offset and compares it with the model, so each result is checked in the exact cycle it becomes due, and neither an early nor a late result escapes. The live count can only be observed by capturing it, so each scenario ends in a capture whose value is predicted by the model.

// File: rtl/latched_counter64_pkg.sv
// Package: register offsets and control-bit positions of the latched counter.
// Assumes byte offsets on a 4-bit address; neighbours decode these values.
package latched_counter64_pkg;
    localparam int OFS_CTRL  = 'h0;
    localparam int OFS_SNAPL = 'h4;
    localparam int OFS_SNAPH = 'h8;

    localparam int CB_CLEAR = 0;
    localparam int CB_GRAB  = 1;
    localparam int CB_SYNC  = 4;
endpackage

// File: rtl/cmd_handshake.sv
// Module: cmd_handshake
// Turns a one-cycle command request into a busy flag that stays high for
// DELAY cycles, and a done pulse in the last of them. A request that arrives
// while busy is dropped. Assumes DELAY >= 1.
module cmd_handshake #(
    parameter int DELAY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = (DELAY > 1) ? $clog2(DELAY) : 1;

    logic [CW-1:0] age;

    assign done = busy && (age == CW'(DELAY - 1));

    // Track how long the current command has been pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            age  <= '0;
        end else if (busy) begin
            if (done) begin
                busy <= 1'b0;
                age  <= '0;
            end else begin
                age <= age + 1'b1;
            end
        end else if (start) begin
            busy <= 1'b1;
            age  <= '0;
        end
    end

    // A new command raises busy on the next edge.
    assert_busy_rises_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    // A repeated request cannot cut short or extend a running command.
    assert_busy_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
    assert_busy_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
endmodule

// File: rtl/free_counter.sv
// Module: free_counter
// Wide up-counter: zeroed on clear, frozen on hold, else +1 per tick.
// Assumes clear wins over hold and tick in the same cycle.
module free_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             hold,
    input  logic             clear,
    output logic [CNT_W-1:0] count
);
    // Advance, hold or zero the count.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count <= '0;
        end else if (tick && !hold) begin
            count <= count + 1'b1;
        end
    end

    assert_tick_inc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !hold && !clear) |=> (count == $past(count) + 1'b1));
    assert_idle_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clear) |=> $stable(count));
    assert_hold_freezes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !clear) |=> $stable(count));
endmodule

// File: rtl/snap_bank.sv
// Module: snap_bank
// Holds one captured copy of the counter; loads it only on capture.
// Assumes capture is a single-cycle pulse.
module snap_bank #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [CNT_W-1:0] count_in,
    output logic [CNT_W-1:0] snap
);
    // Load the snapshot on capture only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap <= '0;
        end else if (capture) begin
            snap <= count_in;
        end
    end

    assert_snap_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(snap));
endmodule

// File: rtl/latched_counter64.sv
// Module: latched_counter64
// Top level: register decode, sync bit, and two command handshakes around a
// free-running counter and its snapshot. Reads are combinational from
// reg_addr. Assumes CNT_W <= 2*DATA_W and a single clock domain.
module latched_counter64 #(
    parameter int CNT_W  = 64,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter int DELAY  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata
);
    import latched_counter64_pkg::*;

    localparam int HI_W = CNT_W - DATA_W;

    logic             ctrl_wr;
    logic             sync_q;
    logic             clr_busy, clr_done;
    logic             grab_busy, grab_done;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] snap_q;
    logic             wdata_unused;

    assign ctrl_wr      = reg_wr && (reg_addr == ADDR_W'(OFS_CTRL));
    assign wdata_unused = ^reg_wdata;

    // Sync bit: loaded by every control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= 1'b0;
        end else if (ctrl_wr) begin
            sync_q <= reg_wdata[CB_SYNC];
        end
    end

    cmd_handshake #(.DELAY(DELAY)) u_clr_hs (
        .clk   (clk),
        .rst_n (rst_n),
        .start (ctrl_wr && reg_wdata[CB_CLEAR]),
        .busy  (clr_busy),
        .done  (clr_done)
    );

    cmd_handshake #(.DELAY(DELAY)) u_grab_hs (
        .clk   (clk),
        .rst_n (rst_n),
        .start (ctrl_wr && reg_wdata[CB_GRAB]),
        .busy  (grab_busy),
        .done  (grab_done)
    );

    free_counter #(.CNT_W(CNT_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .hold  (sync_q),
        .clear (clr_done),
        .count (count_q)
    );

    snap_bank #(.CNT_W(CNT_W)) u_snap (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (grab_done),
        .count_in (count_q),
        .snap     (snap_q)
    );

    // Read mux: status word or one half of the snapshot.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(OFS_CTRL)) begin
            reg_rdata[CB_CLEAR] = clr_busy;
            reg_rdata[CB_GRAB]  = grab_busy;
            reg_rdata[CB_SYNC]  = sync_q;
        end else if (reg_addr == ADDR_W'(OFS_SNAPL)) begin
            reg_rdata = snap_q[DATA_W-1:0];
        end else if (reg_addr == ADDR_W'(OFS_SNAPH)) begin
            reg_rdata = DATA_W'(snap_q[CNT_W-1:DATA_W]);
        end
    end

    // Clear finishing leaves the counter at zero.
    assert_clear_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clr_busy) |-> (count_q == '0));
    // Capture finishing holds the pre-edge count.
    assert_grab_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(grab_busy) |-> (snap_q == $past(count_q)));
    // Sync bit follows control writes only.
    assert_sync_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(sync_q));
    // Width assumption of the read path.
    initial assert_width_fit_R4: assert (HI_W <= DATA_W && HI_W > 0);
endmodule

// File: tb/sim_latched_counter64.sv
`timescale 1ns/100ps
// Bench: behavioural reference model stepped once per rising edge; all
// register offsets are read and compared between edges.
module sim_latched_counter64;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;

    always #2 clk = ~clk;

    latched_counter64 u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;
    string tag = "R1";

    longint unsigned m_cnt = 0;
    longint unsigned m_snap = 0;
    int m_clr_left = 0;
    int m_grab_left = 0;
    bit m_sync = 1'b0;

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic sweep();
        logic [31:0] e;
        e = 32'h0;
        e[0] = (m_clr_left > 0);
        e[1] = (m_grab_left > 0);
        e[4] = m_sync;
        reg_addr = 4'h0; #0.2;
        chk("ctrl word (R4)", reg_rdata, e);
        reg_addr = 4'h4; #0.2;
        chk("snap low (R4 R7)", reg_rdata, m_snap[31:0]);
        reg_addr = 4'h8; #0.2;
        chk("snap high (R4 R7)", reg_rdata, m_snap[63:32]);
        reg_addr = 4'hC; #0.2;
        chk("unused offset (R4)", reg_rdata, 32'h0);
    endtask

    // Advance the reference model by one rising edge with pre-edge inputs.
    task automatic model_edge(bit wr, logic [3:0] a, logic [31:0] d, bit tk);
        bit cmd;
        cmd = wr && (a == 4'h0);
        if (m_grab_left == 1) m_snap = m_cnt;
        if (m_clr_left == 1) m_cnt = 0;
        else if (tk && !m_sync) m_cnt = m_cnt + 1;
        if (m_clr_left > 0) m_clr_left--;
        else if (cmd && d[0]) m_clr_left = 2;
        if (m_grab_left > 0) m_grab_left--;
        else if (cmd && d[1]) m_grab_left = 2;
        if (cmd) m_sync = d[4];
    endtask

    task automatic step(bit wr, logic [3:0] a, logic [31:0] d, bit tk);
        sweep();
        reg_wr = wr; reg_addr = a; reg_wdata = d; tick = tk;
        @(posedge clk);
        model_edge(wr, a, d, tk);
        @(negedge clk);
        reg_wr = 1'b0; tick = 1'b0;
    endtask

    task automatic idle(int n, bit tk);
        for (int i = 0; i < n; i++) step(1'b0, 4'h0, 32'h0, tk);
    endtask

    task automatic grab_and_wait(bit tk);
        step(1'b1, 4'h0, {27'd0, m_sync, 4'b0010}, tk);
        idle(3, tk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        tag = "R1";
        idle(3, 1'b0);

        tag = "R5";
        for (int i = 0; i < 40; i++) step(1'b0, 4'h0, 32'h0, (i % 3) != 0);
        grab_and_wait(1'b1);
        idle(25, 1'b1);

        tag = "R3";
        grab_and_wait(1'b0);
        step(1'b1, 4'h0, 32'h2, 1'b1);
        idle(2, 1'b1);

        tag = "R7";
        for (int i = 0; i < 30; i++) step(1'b0, 4'h0, 32'h0, i[0]);

        tag = "R2";
        step(1'b1, 4'h0, 32'h1, 1'b1);
        idle(2, 1'b1);
        grab_and_wait(1'b1);

        tag = "R6";
        step(1'b1, 4'h0, 32'h10, 1'b1);
        idle(12, 1'b1);
        grab_and_wait(1'b1);
        step(1'b1, 4'h0, 32'h0, 1'b1);
        idle(9, 1'b1);
        grab_and_wait(1'b1);

        tag = "R8";
        idle(7, 1'b1);
        step(1'b1, 4'h0, 32'h3, 1'b1);
        step(1'b1, 4'h0, 32'h3, 1'b1);
        step(1'b1, 4'h0, 32'h3, 1'b1);
        idle(4, 1'b1);
        grab_and_wait(1'b1);

        tag = "R9";
        idle(11, 1'b1);
        step(1'b1, 4'h0, 32'h3, 1'b1);
        idle(3, 1'b0);
        grab_and_wait(1'b0);

        tag = "R10";
        idle(5, 1'b1);
        step(1'b1, 4'h4, 32'hFFFF_FFFF, 1'b1);
        step(1'b1, 4'h8, 32'hFFFF_FFFF, 1'b1);
        step(1'b1, 4'hC, 32'hFFFF_FFFF, 1'b1);
        idle(2, 1'b1);

        tag = "R4";
        step(1'b1, 4'h0, 32'hFFFF_FFEC, 1'b1);
        idle(3, 1'b1);
        grab_and_wait(1'b1);

        tag = "R1";
        rst_n = 1'b0;
        @(posedge clk);
        m_cnt = 0; m_snap = 0; m_clr_left = 0; m_grab_left = 0; m_sync = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        idle(2, 1'b0);
        sweep();

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule